// File: doc/BRIEF.md
# Programmable-Length SPI Master Shift Engine

This block carries out one master-side serial exchange each time a sequencer starts it. On an accepted start it captures the transmit word and the transfer settings. It waits out a lead interval that stands for the time between chip-select assertion and the first clock edge. It then toggles SCK at a rate set by a baud divider, sending MOSI and capturing MISO on the edges chosen by the polarity and phase inputs. When every bit of the selected word length has been exchanged, it pulses done and presents the received word for storage.

The word length for each transfer is either a fixed default of 8 bits or a programmed length of 8 to 16 bits. The lead delay is either a default of half an SCK period or a programmed number of system clocks. Queue management and chip-select patterns belong to the sequencer around this block.

Top module: `spi_xfer_engine`

## Requirements
- R1: While not busy, SCK equals the live `cpol` input. During a transfer SCK starts at the captured `cpol` level and returns to it after the final edge.
- R2: A start with `baud` = 0 is not accepted and busy stays low. With `baud` = N > 0, consecutive SCK edges are N system clocks apart, so the SCK period is 2·N clocks.
- R3: With `cpha` = 0, MISO is captured on the leading edge of each bit, MOSI changes on the trailing edges, and the first bit is on MOSI from the clock that accepts the start. With `cpha` = 1, MOSI changes on leading edges and MISO is captured on trailing edges.
- R4: With `len_sel` = 0 the transfer is 8 bits and `len_code` is ignored. With `len_sel` = 1, codes 8 to 15 give that many bits and codes 0 to 7 give 16 bits.
- R5: The first SCK edge comes max(L,1) clocks after the accepting clock edge. L is `dly_code` when `dly_sel` = 1 and N when `dly_sel` = 0.
- R6: Transmission is MSB first: bits tx_data[len-1] down to tx_data[0] appear on MOSI, and higher bits of `tx_data` are not sent.
- R7: The received word is MSB first and right-aligned in `rx_data`, with bits len and above equal to zero.
- R8: `done` is high for exactly one clock, on the clock edge that makes the final SCK edge. `busy` falls on that same edge, and `rx_data` updates there and holds until the next done.
- R9: A start while busy is ignored: the running transfer's timing, MOSI bits and received word are unaffected.
- R10: `busy` is high from the accepting edge onward, and a transfer makes exactly 2·len SCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a transfer |
| tx_data | input | 16 | Word to send, right-aligned |
| len_sel | input | 1 | 0: default 8 bits, 1: use len_code |
| len_code | input | 4 | Programmed length, 8..15; 0..7 mean 16 |
| dly_sel | input | 1 | 0: half-period lead, 1: use dly_code |
| dly_code | input | 8 | Lead delay in system clocks |
| baud | input | 8 | Half-period of SCK in system clocks; 0 blocks starts |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
A wrong edge counter or length decode shows up on the same transfer as a wrong number of SCK edges, and as a done pulse that comes early or late by whole half-periods. A slip in the divider or lead counter moves the first edge or the spacing between edges by at least one clock, and the bench measures this at every edge. A shift register out of step shows up as a corrupted MOSI word at the peripheral model or as a wrong `rx_data` when done pulses. Every length, phase and polarity is swept with several divider values, so each of these faults appears within one transfer of the affected setting.

// File: rtl/spx_pkg.sv
package spx_pkg;

   typedef enum logic {
      SPX_IDLE = 1'b0,
      SPX_RUN  = 1'b1
   } spx_state_e;

   // Bits in a transfer for a given select and programmed code
   function automatic int spx_len(input bit use_code, input int code,
                                  input int defw, input int maxw);
      if (!use_code)
         return defw;
      else if (code < defw)
         return maxw;
      else
         return code;
   endfunction

endpackage

// File: rtl/spx_timer.sv
module spx_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   input  logic [CNT_W-1:0] reload_val,
   output logic             tick
);

   logic [CNT_W-1:0] cnt;

   assign tick = run && (cnt <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (tick)
         cnt <= reload_val;
      else if (run)
         cnt <= cnt - CNT_W'(1);
   end

endmodule

// File: rtl/spx_ctrl.sv
module spx_ctrl
   import spx_pkg::*;
#(
   parameter int MAXW   = 16,
   parameter int DEFW   = 8,
   parameter int LEN_W  = 4,
   parameter int BAUD_W = 8,
   parameter int LENV_W = $clog2(MAXW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BAUD_W-1:0] baud,
   input  logic              len_sel,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tick,
   output logic              accept,
   output logic              busy,
   output logic              done,
   output logic              sck,
   output logic              sample,
   output logic              drive,
   output logic              last,
   output logic [LENV_W-1:0] len_dec,
   output logic [BAUD_W-1:0] baud_q
);

   localparam int ECNT_W = LENV_W + 1;

   spx_state_e        state;
   logic [ECNT_W-1:0] ecnt;
   logic [ECNT_W-1:0] last_idx;
   logic [LENV_W-1:0] len_q;
   logic              cpol_q;
   logic              cpha_q;
   logic              ph;
   logic              done_q;
   logic              lead_e;
   logic              trail_e;

   always_comb begin
      len_dec = LENV_W'(spx_len(len_sel, int'(len_code), DEFW, MAXW));
   end

   assign accept   = (state == SPX_IDLE) && start && (baud != '0);
   assign busy     = (state == SPX_RUN);
   assign done     = done_q;
   assign last_idx = ECNT_W'({len_q, 1'b0}) - ECNT_W'(1);
   assign lead_e   = tick && !ecnt[0];
   assign trail_e  = tick && ecnt[0];
   assign last     = tick && (ecnt == last_idx);
   assign sample   = cpha_q ? trail_e : lead_e;
   assign drive    = cpha_q ? lead_e  : (trail_e && !last);
   assign sck      = busy ? (cpol_q ^ ph) : cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SPX_IDLE;
         ecnt   <= '0;
         len_q  <= '0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         ph     <= 1'b0;
         done_q <= 1'b0;
         baud_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state  <= SPX_RUN;
            ecnt   <= '0;
            ph     <= 1'b0;
            len_q  <= len_dec;
            cpol_q <= cpol;
            cpha_q <= cpha;
            baud_q <= baud;
         end else if (tick) begin
            ph   <= ~ph;
            ecnt <= ecnt + ECNT_W'(1);
            if (last) begin
               state  <= SPX_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spx_shreg.sv
module spx_shreg #(
   parameter int MAXW   = 16,
   parameter int LENV_W = $clog2(MAXW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [MAXW-1:0]   tx_data,
   input  logic [LENV_W-1:0] len_in,
   input  logic              cpha,
   input  logic              sample,
   input  logic              drive,
   input  logic              miso,
   output logic              mosi,
   output logic [MAXW-1:0]   rx_word
);

   logic [MAXW-1:0]   keep;
   logic [MAXW-1:0]   tx_al;
   logic [MAXW-1:0]   tx_sr;
   logic [MAXW-1:0]   rx_sr;
   logic [MAXW-1:0]   rx_nxt;
   logic [LENV_W-1:0] shamt;
   logic              mosi_q;

   // Per-bit keep mask for the selected length
   for (genvar g = 0; g < MAXW; g++) begin : g_keep
      assign keep[g] = (LENV_W'(g) < len_in);
   end

   assign shamt   = LENV_W'(MAXW) - len_in;
   assign tx_al   = (tx_data & keep) << shamt;
   assign rx_nxt  = {rx_sr[MAXW-2:0], miso};
   assign rx_word = sample ? rx_nxt : rx_sr;
   assign mosi    = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         rx_sr  <= '0;
         mosi_q <= 1'b0;
      end else if (accept) begin
         rx_sr <= '0;
         if (!cpha) begin
            mosi_q <= tx_al[MAXW-1];
            tx_sr  <= tx_al << 1;
         end else begin
            tx_sr <= tx_al;
         end
      end else begin
         if (drive) begin
            mosi_q <= tx_sr[MAXW-1];
            tx_sr  <= tx_sr << 1;
         end
         if (sample)
            rx_sr <= rx_nxt;
      end
   end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
   parameter int MAXW   = 16,
   parameter int DEFW   = 8,
   parameter int BAUD_W = 8,
   parameter int DLY_W  = 8,
   parameter int LEN_W  = $clog2(MAXW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MAXW-1:0]   tx_data,
   input  logic              len_sel,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              dly_sel,
   input  logic [DLY_W-1:0]  dly_code,
   input  logic [BAUD_W-1:0] baud,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [MAXW-1:0]   rx_data
);

   localparam int LENV_W = $clog2(MAXW + 1);
   localparam int CNT_W  = (BAUD_W > DLY_W) ? BAUD_W : DLY_W;

   if (DEFW < 2 || DEFW > MAXW) begin : g_bad_defw
      $error("DEFW must lie between 2 and MAXW");
   end
   if ((1 << LEN_W) < MAXW) begin : g_bad_lenw
      $error("LEN_W too narrow for MAXW");
   end

   logic              accept;
   logic              tick;
   logic              sample;
   logic              drive;
   logic              last;
   logic [LENV_W-1:0] len_dec;
   logic [BAUD_W-1:0] baud_q;
   logic [CNT_W-1:0]  lead_val;
   logic [MAXW-1:0]   rx_word;
   logic [MAXW-1:0]   rx_q;

   assign lead_val = dly_sel ? CNT_W'(dly_code) : CNT_W'(baud);

   spx_ctrl #(
      .MAXW(MAXW), .DEFW(DEFW), .LEN_W(LEN_W), .BAUD_W(BAUD_W), .LENV_W(LENV_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .baud(baud),
      .len_sel(len_sel), .len_code(len_code), .cpol(cpol), .cpha(cpha),
      .tick(tick), .accept(accept), .busy(busy), .done(done), .sck(sck),
      .sample(sample), .drive(drive), .last(last), .len_dec(len_dec),
      .baud_q(baud_q)
   );

   spx_timer #(.CNT_W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(lead_val),
      .run(busy), .reload_val(CNT_W'(baud_q)), .tick(tick)
   );

   spx_shreg #(.MAXW(MAXW), .LENV_W(LENV_W)) i_shreg (
      .clk(clk), .rst_n(rst_n), .accept(accept), .tx_data(tx_data),
      .len_in(len_dec), .cpha(cpha), .sample(sample), .drive(drive),
      .miso(miso), .mosi(mosi), .rx_word(rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= '0;
      else if (last)
         rx_q <= rx_word;
   end

   assign rx_data = rx_q;

endmodule

// File: rtl/spx_chk.sv
module spx_chk #(
   parameter int BAUD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [BAUD_W-1:0] baud,
   input logic              cpol,
   input logic              sck,
   input logic              busy,
   input logic              done
);

   // R1
   idle_sck_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == cpol));

   // R2
   zero_baud_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (baud == '0)) |=> !busy);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (baud != '0)) |=> busy);

endmodule

bind spi_xfer_engine spx_chk #(.BAUD_W(BAUD_W)) i_spx_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .baud(baud), .cpol(cpol),
   .sck(sck), .busy(busy), .done(done)
);

// File: tb/test_spi_xfer_engine.sv
`timescale 1ns/1ps
module test_spi_xfer_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] tx_data = '0;
   logic        len_sel = 1'b0;
   logic [3:0]  len_code = '0;
   logic        dly_sel = 1'b0;
   logic [7:0]  dly_code = '0;
   logic [7:0]  baud = 8'd1;
   logic        cpol = 1'b0;
   logic        cpha = 1'b0;
   logic        miso = 1'b0;
   logic        sck, mosi, busy, done;
   logic [15:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   spi_xfer_engine i_spi_xfer_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
      .len_sel(len_sel), .len_code(len_code), .dly_sel(dly_sel),
      .dly_code(dly_code), .baud(baud), .cpol(cpol), .cpha(cpha),
      .miso(miso), .sck(sck), .mosi(mosi), .busy(busy), .done(done),
      .rx_data(rx_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_xfer(input bit pol, input bit pha, input bit lsel,
                           input int lcode, input bit dsel, input int dcode,
                           input int n, input int tx, input int sl, input bit poke);
      int len, lead, tend, mask, edges, lastc, got, p, c;
      logic prev;
      bit lead_edge, smp, seen_done;
      len  = lsel ? ((lcode < 8) ? 16 : lcode) : 8;
      lead = dsel ? dcode : n;
      if (lead < 1) lead = 1;
      tend = lead + (2 * len - 1) * n;
      mask = (1 << len) - 1;
      edges = 0; lastc = 0; got = 0; seen_done = 0;
      @(negedge clk);
      cpol = pol; cpha = pha; len_sel = lsel; len_code = 4'(lcode);
      dly_sel = dsel; dly_code = 8'(dcode); baud = 8'(n);
      tx_data = 16'(tx);
      if (!pha) begin
         miso = 1'((sl >> (len - 1)) & 1);
         p = len - 2;
      end else begin
         p = len - 1;
      end
      start = 1'b1;
      prev = pol;
      @(posedge clk);
      for (c = 0; c < 5000; c++) begin
         @(negedge clk);
         if (c == 0) begin
            start = 1'b0;
            // R10: busy from the accepting edge
            chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
         end
         if (poke && c == 2) begin start = 1'b1; tx_data = 16'(~tx); end
         if (poke && c == 3) start = 1'b0;
         if (sck !== prev) begin
            edges++;
            lead_edge = (sck != pol);
            if (edges == 1)
               chk(c == lead, "R5 first edge time", c, lead);
            else if (c - lastc != n) begin
               chk(0, "R2 edge spacing", c - lastc, n);
            end
            lastc = c;
            smp = pha ? !lead_edge : lead_edge;
            if (smp) begin
               got = (got << 1) | int'(mosi);
            end else begin
               if (p >= 0) miso = 1'((sl >> p) & 1);
               p--;
            end
            prev = sck;
         end
         if (done) begin seen_done = 1; break; end
      end
      chk(seen_done, "R8 done seen", int'(seen_done), 1);
      chk(c == tend, "R8 done timing", c, tend);
      chk(busy == 1'b0, "R8 busy falls with done", int'(busy), 0);
      chk(edges == 2 * len, "R10 R4 edge count", edges, 2 * len);
      chk(sck == pol, "R1 sck back to idle", int'(sck), int'(pol));
      // R6 R3 R9: MOSI word seen by the peripheral
      chk(got == (tx & mask), "R6 R3 R9 mosi word", got, tx & mask);
      // R7 R3 R9: received word right-aligned
      chk(int'(rx_data) == (sl & mask), "R7 R3 R9 rx word", int'(rx_data), sl & mask);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
      chk(int'(rx_data) == (sl & mask), "R8 rx held", int'(rx_data), sl & mask);
   endtask

   initial begin
      int k;
      k = 0;
      repeat (3) @(negedge clk);
      // reset state
      chk(busy == 1'b0 && done == 1'b0, "R8 reset flags", int'({busy, done}), 0);
      chk(rx_data == 16'h0 && mosi == 1'b0, "R7 reset data", int'(rx_data), 0);
      chk(sck == 1'b0, "R1 reset sck", int'(sck), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cpol = 1'b1;
      @(negedge clk);
      chk(sck == 1'b1, "R1 idle follows cpol", int'(sck), 1);
      // R2: zero divider blocks a start
      baud = 8'd0; start = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(busy == 1'b0, "R2 zero baud ignored", int'(busy), 0);
      end
      start = 1'b0;
      for (int cp = 0; cp < 4; cp++) begin
         for (int li = 0; li < 17; li++) begin
            for (int bi = 1; bi <= 3; bi++) begin
               int tx, sl;
               tx = (16'hA5C3 ^ (k * 16'h1357)) & 16'hFFFF;
               sl = (16'h3C69 + k * 16'h0B1D) & 16'hFFFF;
               if (li == 0)
                  // R4: code ignored when default length selected
                  run_xfer(cp[1], cp[0], 1'b0, 3, li % 2 == 1, (li * 3) % 7,
                           bi, tx, sl, (k % 5) == 0);
               else
                  run_xfer(cp[1], cp[0], 1'b1, li - 1, li % 2 == 1, (li * 3) % 7,
                           bi, tx, sl, (k % 5) == 0);
               k++;
            end
         end
      end
      // R5: long programmed lead and default lead with a slow clock
      run_xfer(1'b0, 1'b1, 1'b1, 12, 1'b1, 40, 4, 16'h0F0F, 16'hBEEF, 1'b1);
      run_xfer(1'b1, 1'b0, 1'b0, 0, 1'b0, 99, 7, 16'h00A5, 16'h005A, 1'b0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule